// File: doc/BRIEF.md
# Flash Command Sequencer

This block decodes host bus write cycles for a flash-style memory. Each write carries an address and a data word, and the low byte of the data word is the command code. The block keeps track of which source the host read path returns: array, status or extended status. It turns two-cycle setup/confirm sequences into single-cycle start strobes for the program/erase engine, and each strobe carries an operation type and payload. It can suspend and resume the engine. It also runs a buffered multi-word write: a count phase, then a stream of buffer-load beats, then a confirm.

All host and engine signals are plain strobes and levels. The block applies no back-pressure. The host must present one write cycle per `bus_wr` pulse, and it must not depend on any acknowledge. The engine is represented only by its `eng_busy` level. Every output strobe is registered, is high for exactly one clock, and appears in the cycle after the bus write that caused it.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `rd_sel` is 0 (array) and all strobes are low.
- R2: Read-source encoding is 0 = array, 1 = status, 2 = extended status. Command FFh selects 0 and command 70h selects 1.
- R3: Setup 40h or 10h followed by any write cycle produces `eng_start` with `eng_op` = 1 (word write), and the address and data of that second cycle on `eng_addr` and `eng_data`. `rd_sel` becomes 1 and stays 1 until FFh is written.
- R4: 30h followed by D0h produces `eng_start` with `eng_op` = 2 (chip erase). 30h followed by any other code produces `seq_err`, gives no start, and sets `rd_sel` to 1.
- R5: While `eng_busy` is high, only 70h (status select) and B0h (suspend) have any effect. Every other write leaves the outputs and the sequence state unchanged.
- R6: B0h while busy and not suspended produces `eng_suspend` and sets status mode. D0h while suspended and idle produces `eng_resume`. B0h while not busy is ignored.
- R7: While a word write is suspended, `rd_block` is high exactly when `rd_addr` equals that write's address. A suspended erase never blocks, and resuming clears the block.
- R8: While suspended, any setup code (40h, 10h, 30h, E8h) produces `seq_err` and starts nothing.
- R9: E8h sets `rd_sel` to 2. The next cycle loads N-1 from data bits 7:0 and takes its address as the start address. A value of MAX_WORDS or more produces `seq_err`.
- R10: Each of the N following cycles pulses `buf_load` with its address and data. A following D0h produces `eng_start` with `eng_op` = 3, `eng_addr` = the start address and `eng_count` = N-1. Any other code produces `seq_err`.
- R11: A buffer beat whose address bits above the block offset differ from those of the start address produces `seq_err` and no `buf_load`, and returns the block to command decoding in status mode.
- R12: D0h arriving outside any sequence while not suspended produces `seq_err`. Unknown codes are ignored.
- R13: At most one of `eng_start`, `buf_load`, `eng_suspend`, `eng_resume`, `seq_err` is high in any cycle, and each is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write cycle strobe |
| bus_addr | input | AW | Host write address |
| bus_data | input | DW | Host write data; bits 7:0 are the command code |
| eng_busy | input | 1 | Engine is executing an operation |
| rd_addr | input | AW | Host read address, checked against a suspended write |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 extended status |
| eng_start | output | 1 | Start strobe to the engine |
| eng_op | output | 2 | Operation: 1 word write, 2 chip erase, 3 multi-word write |
| eng_addr | output | AW | Address for a start or a buffer beat |
| eng_data | output | DW | Data for a word write or a buffer beat |
| eng_count | output | CW | Multi-word count N-1 |
| buf_load | output | 1 | Buffer beat strobe |
| eng_suspend | output | 1 | Suspend strobe |
| eng_resume | output | 1 | Resume strobe |
| seq_err | output | 1 | Improper command sequence strobe |
| rd_block | output | 1 | Read of the suspended write location is not allowed |

## Verification
The final buffer beat of a multi-word write is the one cycle where the beat counter reaching zero and an out-of-block abort can fall together. The bench provokes this case in a directed test: the first of two beats stays inside the block and the last one leaves it. The result is judged by `seq_err` firing with no `buf_load`. A following D0h must then be treated as a stray confirm (`seq_err`) and not as a start, which shows that the sequence was really abandoned.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_STATUS = 2'd1, RD_XSTATUS = 2'd2} rdsel_e;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_WRITE = 2'd1, OP_ERASE = 2'd2, OP_MULTI = 2'd3} op_e;
  typedef enum logic [2:0] {ST_CMD, ST_WR_DATA, ST_ER_CONF, ST_MW_COUNT, ST_MW_DATA, ST_MW_CONF} seq_e;

  localparam logic [7:0] C_READ    = 8'hFF;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_WR_A    = 8'h40;
  localparam logic [7:0] C_WR_B    = 8'h10;
  localparam logic [7:0] C_ERASE   = 8'h30;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_SUSPEND = 8'hB0;
  localparam logic [7:0] C_MULTI   = 8'hE8;
endpackage

// File: rtl/fcs_block_match.sv
module fcs_block_match #(
  parameter int AW  = 22,
  parameter int OFS = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output logic          same
);
  generate
    if (OFS >= AW) begin : g_whole
      assign same = 1'b1;
    end else begin : g_cmp
      assign same = (addr[AW-1:OFS] == base[AW-1:OFS]);
    end
  endgenerate
endmodule

// File: rtl/fcs_beat_counter.sv
module fcs_beat_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] size,
  output logic          last
);
  logic [CW-1:0] left_q;
  logic [CW-1:0] size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      size_q <= '0;
    end else if (load) begin
      left_q <= load_val;
      size_q <= load_val;
    end else if (dec) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign size = size_q;
  assign last = (left_q == '0);
endmodule

// File: rtl/fcs_suspend_track.sv
module fcs_suspend_track #(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_susp,
  input  logic          set_is_write,
  input  logic          clr_susp,
  input  logic          loc_load,
  input  logic [AW-1:0] loc_addr,
  input  logic [AW-1:0] rd_addr,
  output logic          suspended,
  output logic          rd_block
);
  logic          susp_q;
  logic          wr_susp_q;
  logic [AW-1:0] loc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      susp_q    <= 1'b0;
      wr_susp_q <= 1'b0;
      loc_q     <= '0;
    end else begin
      if (loc_load) loc_q <= loc_addr;
      if (set_susp) begin
        susp_q    <= 1'b1;
        wr_susp_q <= set_is_write;
      end else if (clr_susp) begin
        susp_q    <= 1'b0;
        wr_susp_q <= 1'b0;
      end
    end
  end

  assign suspended = susp_q;
  assign rd_block  = susp_q && wr_susp_q && (rd_addr == loc_q);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int AW          = 22,
  parameter int DW          = 16,
  parameter int BLOCK_WORDS = 65536,
  parameter int MAX_WORDS   = 32,
  localparam int OFS        = $clog2(BLOCK_WORDS),
  localparam int CW         = $clog2(MAX_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          eng_busy,
  input  logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_sel,
  output logic          eng_start,
  output logic [1:0]    eng_op,
  output logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_data,
  output logic [CW-1:0] eng_count,
  output logic          buf_load,
  output logic          eng_suspend,
  output logic          eng_resume,
  output logic          seq_err,
  output logic          rd_block
);
  logic [7:0] cmd;
  assign cmd = bus_data[7:0];

  seq_e          st_q, st_n;
  rdsel_e        rd_q, rd_n;
  op_e           op_q, op_n;
  logic [AW-1:0] addr_q, addr_n, base_q;
  logic [DW-1:0] data_q, data_n;
  logic          start_q, start_n, ld_q, ld_n, sus_q, sus_n, res_q, res_n, err_q, err_n;
  logic          base_ld, cnt_ld, cnt_dec, loc_ld;
  logic          suspended, in_blk, cnt_last, fits;
  logic [CW-1:0] cnt_size;

  assign fits = (32'(cmd) < 32'(MAX_WORDS));

  fcs_block_match #(.AW(AW), .OFS(OFS)) u_blk (
    .addr(bus_addr), .base(base_q), .same(in_blk));

  fcs_beat_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_ld), .load_val(bus_data[CW-1:0]),
    .dec(cnt_dec), .size(cnt_size), .last(cnt_last));

  fcs_suspend_track #(.AW(AW)) u_sus (
    .clk(clk), .rst_n(rst_n), .set_susp(sus_n), .set_is_write(op_q == OP_WRITE),
    .clr_susp(res_n), .loc_load(loc_ld), .loc_addr(bus_addr), .rd_addr(rd_addr),
    .suspended(suspended), .rd_block(rd_block));

  always_comb begin
    st_n = st_q;   rd_n = rd_q;   op_n = op_q;
    addr_n = addr_q; data_n = data_q;
    start_n = 1'b0; ld_n = 1'b0; sus_n = 1'b0; res_n = 1'b0; err_n = 1'b0;
    base_ld = 1'b0; cnt_ld = 1'b0; cnt_dec = 1'b0; loc_ld = 1'b0;
    if (bus_wr) begin
      if (eng_busy) begin
        if (cmd == C_STATUS) rd_n = RD_STATUS;
        else if (cmd == C_SUSPEND && !suspended) begin
          sus_n = 1'b1;
          rd_n  = RD_STATUS;
        end
      end else begin
        unique case (st_q)
          ST_CMD: begin
            unique case (cmd)
              C_READ:   rd_n = RD_ARRAY;
              C_STATUS: rd_n = RD_STATUS;
              C_WR_A, C_WR_B, C_ERASE, C_MULTI: begin
                if (suspended) begin
                  err_n = 1'b1;
                  rd_n  = RD_STATUS;
                end else if (cmd == C_MULTI) begin
                  st_n = ST_MW_COUNT;
                  rd_n = RD_XSTATUS;
                end else begin
                  st_n = (cmd == C_ERASE) ? ST_ER_CONF : ST_WR_DATA;
                  rd_n = RD_STATUS;
                end
              end
              C_CONFIRM: begin
                rd_n = RD_STATUS;
                if (suspended) res_n = 1'b1;
                else           err_n = 1'b1;
              end
              default: ;
            endcase
          end
          ST_WR_DATA: begin
            start_n = 1'b1; op_n = OP_WRITE;
            addr_n = bus_addr; data_n = bus_data; loc_ld = 1'b1;
            st_n = ST_CMD; rd_n = RD_STATUS;
          end
          ST_ER_CONF: begin
            if (cmd == C_CONFIRM) begin
              start_n = 1'b1; op_n = OP_ERASE; addr_n = '0;
            end else err_n = 1'b1;
            st_n = ST_CMD; rd_n = RD_STATUS;
          end
          ST_MW_COUNT: begin
            if (fits) begin
              base_ld = 1'b1; cnt_ld = 1'b1; st_n = ST_MW_DATA;
            end else begin
              err_n = 1'b1; st_n = ST_CMD; rd_n = RD_STATUS;
            end
          end
          ST_MW_DATA: begin
            if (!in_blk) begin
              err_n = 1'b1; st_n = ST_CMD; rd_n = RD_STATUS;
            end else begin
              ld_n = 1'b1; addr_n = bus_addr; data_n = bus_data;
              if (cnt_last) st_n = ST_MW_CONF;
              else          cnt_dec = 1'b1;
            end
          end
          ST_MW_CONF: begin
            if (cmd == C_CONFIRM) begin
              start_n = 1'b1; op_n = OP_MULTI; addr_n = base_q;
            end else err_n = 1'b1;
            st_n = ST_CMD; rd_n = RD_STATUS;
          end
          default: st_n = ST_CMD;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_CMD; rd_q <= RD_ARRAY; op_q <= OP_NONE;
      addr_q <= '0; data_q <= '0; base_q <= '0;
      start_q <= 1'b0; ld_q <= 1'b0; sus_q <= 1'b0; res_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_n; rd_q <= rd_n; op_q <= op_n;
      addr_q <= addr_n; data_q <= data_n;
      if (base_ld) base_q <= bus_addr;
      start_q <= start_n; ld_q <= ld_n; sus_q <= sus_n; res_q <= res_n; err_q <= err_n;
    end
  end

  assign rd_sel      = rd_q;
  assign eng_start   = start_q;
  assign eng_op      = op_q;
  assign eng_addr    = addr_q;
  assign eng_data    = data_q;
  assign eng_count   = cnt_size;
  assign buf_load    = ld_q;
  assign eng_suspend = sus_q;
  assign eng_resume  = res_q;
  assign seq_err     = err_q;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       eng_busy,
  input logic [1:0] rd_sel,
  input logic       eng_start,
  input logic       buf_load,
  input logic       eng_suspend,
  input logic       eng_resume,
  input logic       seq_err,
  input logic       rd_block
);
  AST_RESET_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_sel == 2'd0); // R1
  AST_START_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> rd_sel == 2'd1); // R3
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && bus_wr) |=> !(eng_start || buf_load || eng_resume || seq_err)); // R5
  AST_RESUME_UNBLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_resume |-> !rd_block); // R7
  AST_LOAD_IN_XSTATUS: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |-> rd_sel == 2'd2); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_start, buf_load, eng_suspend, eng_resume, seq_err})); // R13
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R13
endmodule

bind flash_cmd_seq fcs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .eng_busy(eng_busy), .rd_sel(rd_sel),
  .eng_start(eng_start), .buf_load(buf_load), .eng_suspend(eng_suspend),
  .eng_resume(eng_resume), .seq_err(seq_err), .rd_block(rd_block));

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic          eng_busy = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0]    rd_sel, eng_op;
  logic          eng_start, buf_load, eng_suspend, eng_resume, seq_err, rd_block;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] eng_data;
  logic [CW-1:0] eng_count;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data),
    .eng_busy(eng_busy), .rd_addr(rd_addr), .rd_sel(rd_sel), .eng_start(eng_start),
    .eng_op(eng_op), .eng_addr(eng_addr), .eng_data(eng_data), .eng_count(eng_count),
    .buf_load(buf_load), .eng_suspend(eng_suspend), .eng_resume(eng_resume),
    .seq_err(seq_err), .rd_block(rd_block));

  typedef struct packed {
    logic wr; logic [21:0] a; logic [15:0] d; logic bsy;
    logic [1:0] rd; logic st; logic [1:0] op; logic er; logic su; logic re; logic ld;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 22'h0,     16'h0070, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00FF, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h100,   16'h0040, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h123,   16'hABCD, 1'b0, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h0030, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00FF, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00B0, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 22'h0,     16'h0000, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00FF, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h0040, 1'b0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00D0, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 22'h0,     16'h0000, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 22'h0,     16'h0000, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00FF, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h0030, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00D0, 1'b0, 2'd1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h0030, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h0055, 1'b0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00D0, 1'b0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00FF, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h0077, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h0010, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h200,   16'h0042, 1'b0, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h10000, 16'h00E8, 1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h10000, 16'h0001, 1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h10005, 16'h1111, 1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 22'h1FFFF, 16'h2222, 1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 22'h10000, 16'h00D0, 1'b0, 2'd1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h20000, 16'h00E8, 1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h20000, 16'h0002, 1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h20001, 16'h3333, 1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 22'h30000, 16'h4444, 1'b0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00D0, 1'b0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00E8, 1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h0000, 1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h5,     16'h5555, 1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 22'h0,     16'h00FF, 1'b0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00E8, 1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h0040, 1'b0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 22'h0,     16'h00B0, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic string tag_of(input int i);
    if (i <= 1 || i == 13 || i == 19) return "R2";
    if (i <= 3 || i == 21 || i == 22) return "R3";
    if (i <= 5) return "R5";
    if (i <= 8 || (i >= 10 && i <= 12) || i == 39) return "R6";
    if (i == 9) return "R8";
    if (i <= 17) return "R4";
    if (i == 18 || i == 20) return "R12";
    if (i == 23 || i == 24 || i == 37 || i == 38) return "R9";
    if (i >= 28 && i <= 32) return "R11";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic b);
    bus_wr = w; bus_addr = a; bus_data = d; eng_busy = b;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", {62'd0, rd_sel}, 64'd0);
    check("R1", {59'd0, eng_start, buf_load, eng_suspend, eng_resume, seq_err}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].wr, TBL[i].a, TBL[i].d, TBL[i].bsy);
      check(tag_of(i),
        {55'd0, rd_sel, eng_start, (TBL[i].st ? eng_op : 2'd0), seq_err, eng_suspend, eng_resume, buf_load},
        {55'd0, TBL[i].rd, TBL[i].st, TBL[i].op, TBL[i].er, TBL[i].su, TBL[i].re, TBL[i].ld});
    end
    step(1'b0, '0, '0, 1'b0);

    // R3: word-write payload
    step(1'b1, '0, 16'h0040, 1'b0);
    step(1'b1, 22'h1234, 16'hBEEF, 1'b0);
    check("R3", {42'd0, eng_addr}, {42'd0, 22'h1234});
    check("R3", {48'd0, eng_data}, {48'd0, 16'hBEEF});
    // R13: strobe lasts one cycle
    step(1'b0, '0, '0, 1'b1);
    check("R13", {63'd0, eng_start}, 64'd0);

    // R7: suspended write blocks only its own location
    step(1'b1, '0, 16'h00B0, 1'b1);
    step(1'b0, '0, '0, 1'b0);
    rd_addr = 22'h1234; #1;
    check("R7", {63'd0, rd_block}, 64'd1);
    rd_addr = 22'h1235; #1;
    check("R7", {63'd0, rd_block}, 64'd0);
    rd_addr = 22'h1234;
    step(1'b1, '0, 16'h00D0, 1'b0);
    check("R7", {62'd0, eng_resume, rd_block}, {62'd0, 2'b10});
    step(1'b0, '0, '0, 1'b0);

    // R7: suspended erase never blocks
    step(1'b1, '0, 16'h0030, 1'b0);
    step(1'b1, '0, 16'h00D0, 1'b0);
    step(1'b1, '0, 16'h00B0, 1'b1);
    step(1'b0, '0, '0, 1'b0);
    #1;
    check("R7", {62'd0, eng_suspend, rd_block}, 64'd0);
    step(1'b1, '0, 16'h00D0, 1'b0);
    step(1'b0, '0, '0, 1'b0);

    // R10: multi-word start address and count
    step(1'b1, 22'h40000, 16'h00E8, 1'b0);
    step(1'b1, 22'h40000, 16'h0002, 1'b0);
    for (int k = 0; k < 3; k++) step(1'b1, 22'h40000 + AW'(k), 16'h0100 + 16'(k), 1'b0);
    check("R10", {42'd0, eng_addr}, {42'd0, 22'h40002});
    step(1'b1, 22'h0, 16'h00D0, 1'b0);
    check("R10", {63'd0, eng_start}, 64'd1);
    check("R10", {42'd0, eng_addr}, {42'd0, 22'h40000});
    check("R10", {59'd0, eng_count}, 64'd2);

    // R11: last beat leaves the block while the count reaches zero
    step(1'b1, 22'h50000, 16'h00E8, 1'b0);
    step(1'b1, 22'h50000, 16'h0001, 1'b0);
    step(1'b1, 22'h5FFFE, 16'h0AAA, 1'b0);
    check("R11", {63'd0, buf_load}, 64'd1);
    step(1'b1, 22'h60000, 16'h0BBB, 1'b0);
    check("R11", {62'd0, seq_err, buf_load}, {62'd0, 2'b10});
    step(1'b1, 22'h0, 16'h00D0, 1'b0);
    check("R11", {62'd0, eng_start, seq_err}, {62'd0, 2'b01});

    // R1: reset mid-run returns to array mode
    step(1'b0, '0, '0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", {62'd0, rd_sel}, 64'd0);

    finish_run();
  end
endmodule